// File: doc/BRIEF.md
# Selectable Tick Counter with Frame Capture

This block counts events from one of four line-interface tick sources and publishes the count as a periodic snapshot instead of a live value. Software picks the source through a write-only select field. A free-running event counter then advances once for every clock cycle in which the chosen source pulses. Each USB start-of-frame event copies the running count into a holding register, and software reads that holding register. Each sample therefore covers one frame interval, and software takes the difference between two consecutive samples to get the event rate.

The block also holds a wide free-running time counter that advances on every system clock, so software can timestamp what it reads. Register access uses a simple synchronous write strobe. Reads are combinational, decoded from a read address. The logic that generates the tick pulses and the logic that detects start-of-frame are outside this block. Both arrive here as single-cycle pulses.

Top module: `tick_capture_unit`

## Requirements
- R1: After reset the capture register, the event counter and the time counter are all zero, and the source select is 0.
- R2: A write with wr_addr = 0x4 loads wr_data[1:0] into the source select, and the new value takes effect from the next cycle. Code 0 selects tick_src[0] (transmit bit tick), 1 selects tick_src[1] (receive pulse detected), 2 selects tick_src[2] (receive bit sample), and 3 selects tick_src[3] (received one bit).
- R3: The event counter increases by one in every cycle in which the selected source is high. Pulses on the sources that are not selected have no effect.
- R4: In a cycle where sof is high, the event counter value is copied into the capture register. A read with rd_addr = 0x4 returns the capture register in rd_data[15:0], with zeros above.
- R5: The capture register keeps its value in every cycle without sof.
- R6: The 16-bit event counter wraps modulo 65536, and a capture does not clear it.
- R7: When a selected tick and sof fall in the same cycle, the captured value excludes that tick, and the counter still counts it.
- R8: Changing the source select leaves the event counter value unchanged.
- R9: A read with rd_addr = 0x8 returns the 32-bit time counter, which increases by one on every clock after reset.
- R10: Writes to any address other than 0x4 are ignored, and reads of any address other than 0x4 and 0x8 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 4 | Tick pulses: [0] transmit bit, [1] receive pulse, [2] receive sample, [3] received one |
| sof | input | 1 | Start-of-frame pulse that triggers a capture |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |

## Verification
A selected tick and a start-of-frame capture can arrive in the same cycle. That is the one collision that decides what a snapshot contains. The bench forces it directly: it captures a baseline, then raises the selected tick and sof together. It expects the capture to equal the baseline, and it expects the next capture to show the baseline plus one. Random traffic with frequent sof and dense ticks also produces this overlap many times. Each of those cycles is judged against a bench model whose capture takes the counter value from before the edge.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
   typedef enum logic [1:0] {
      SRC_TX_BIT    = 2'd0,
      SRC_RX_PULSE  = 2'd1,
      SRC_RX_SAMPLE = 2'd2,
      SRC_RX_ONE    = 2'd3
   } tick_src_e;

   localparam int unsigned DEF_CNT_W  = 16;
   localparam int unsigned DEF_TIME_W = 32;
   localparam int unsigned DEF_NSRC   = 4;
endpackage

// File: rtl/tcu_src_mux.sv
module tcu_src_mux #(
   parameter int unsigned N_SRC = 4,
   parameter int unsigned SEL_W = 2
) (
   input  logic [N_SRC-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [N_SRC-1:0] hit;

   for (genvar i = 0; i < N_SRC; i++) begin : g_hit
      assign hit[i] = src[i] && (sel == SEL_W'(i));
   end

   assign tick = |hit;
endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] STEP = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)   value <= '0;
      else if (inc) value <= value + STEP;
   end
endmodule

// File: rtl/tcu_capture.sv
module tcu_capture #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/tick_capture_unit.sv
module tick_capture_unit #(
   parameter int unsigned CNT_W    = tcu_pkg::DEF_CNT_W,
   parameter int unsigned TIME_W   = tcu_pkg::DEF_TIME_W,
   parameter int unsigned N_SRC    = tcu_pkg::DEF_NSRC,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SEL_OFS  = 4,
   parameter int unsigned TIME_OFS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  tick_src,
   input  logic              sof,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(SEL_OFS);
   localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(TIME_OFS);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must be between 1 and DATA_W");
   end
   if (TIME_W < 1 || TIME_W > DATA_W) begin : g_bad_time
      $error("TIME_W must be between 1 and DATA_W");
   end
   if (SEL_OFS == TIME_OFS) begin : g_bad_ofs
      $error("register offsets must differ");
   end
   if (SEL_W > DATA_W) begin : g_bad_sel
      $error("select field wider than data bus");
   end

   logic [SEL_W-1:0]  sel_q;
   logic              sel_wr;
   logic              tick_sel;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cap;
   logic [TIME_W-1:0] time_v;

   assign sel_wr = wr_en && (wr_addr == A_SEL);

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_wr) sel_q <= wr_data[SEL_W-1:0];
   end

   tcu_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
      .src  (tick_src),
      .sel  (sel_q),
      .tick (tick_sel)
   );

   tcu_counter #(.W(CNT_W)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tick_sel),
      .value (cnt)
   );

   tcu_capture #(.W(CNT_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sof),
      .d     (cnt),
      .q     (cap)
   );

   tcu_counter #(.W(TIME_W)) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (1'b1),
      .value (time_v)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_SEL)       rd_data = DATA_W'(cap);
      else if (rd_addr == A_TIME) rd_data = DATA_W'(time_v);
   end
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned TIME_W = 32,
   parameter int unsigned SEL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              sof,
   input logic              sel_wr,
   input logic [SEL_W-1:0]  sel,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cap,
   input logic [TIME_W-1:0] time_v
);
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

   a_r3_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   a_r7_capture_old: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> cap == $past(cnt));

   a_r5_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> $stable(cap));

   a_r9_time_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> time_v == TIME_W'($past(time_v) + 1'b1));

   a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> $stable(sel));
endmodule

bind tick_capture_unit tcu_checker #(
   .CNT_W(CNT_W), .TIME_W(TIME_W), .SEL_W(SEL_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick_sel),
   .sof    (sof),
   .sel_wr (sel_wr),
   .sel    (sel_q),
   .cnt    (cnt),
   .cap    (cap),
   .time_v (time_v)
);

// File: tb/tick_capture_unit_test.sv
module tick_capture_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tick_src = '0;
   logic        sof = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;

   logic [1:0]  m_sel;
   logic [15:0] m_cnt;
   logic [15:0] m_cap;
   logic [31:0] m_time;

   always #5 clk = ~clk;

   tick_capture_unit uut (
      .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .sof(sof),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // Reference model built from the requirements.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel <= 2'd0; m_cnt <= '0; m_cap <= '0; m_time <= '0;
      end else begin
         if (tick_src[m_sel]) m_cnt <= m_cnt + 16'd1;
         if (sof) m_cap <= m_cnt;
         if (wr_en && wr_addr == 4'h4) m_sel <= wr_data[1:0];
         m_time <= m_time + 32'd1;
      end
   end

   function automatic logic [31:0] exp_cap_word(input logic [15:0] c);
      return {16'h0, c};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read(input logic [3:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic cyc(input logic [3:0] t, input logic s, input logic we,
                      input logic [3:0] wa, input logic [31:0] wd);
      tick_src = t; sof = s; wr_en = we; wr_addr = wa; wr_data = wd;
      @(posedge clk);
      @(negedge clk);
      tick_src = '0; sof = 1'b0; wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(4'h0, 1'b0, 1'b0, 4'h0, 32'h0);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v, t0;
      logic [15:0] base;
      void'($urandom(32'h5eed_1234));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      read(4'h4, v); check("R1 capture", v, 32'h0);
      read(4'h8, v); check("R1 time", v, 32'h0);
      // R1: select defaults to source 0
      cyc(4'b0001, 1'b0, 1'b0, 4'h0, 32'h0);
      cyc(4'b1110, 1'b0, 1'b0, 4'h0, 32'h0);
      cyc(4'b0001, 1'b0, 1'b0, 4'h0, 32'h0);
      cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); check("R1 default select", v, 32'd2);

      // R2/R3: each source individually
      for (int i = 0; i < 4; i++) begin
         cyc(4'h0, 1'b1, 1'b1, 4'h4, 32'(i));
         read(4'h4, v); base = v[15:0];
         for (int k = 0; k < 3; k++) cyc(~(4'b1 << i), 1'b0, 1'b0, 4'h0, 32'h0);
         for (int k = 0; k < 4; k++) cyc(4'b1 << i, 1'b0, 1'b0, 4'h0, 32'h0);
         cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
         read(4'h4, v); check("R2 R3 source count", v, exp_cap_word(base + 16'd4));
      end

      // R7: tick and sof together
      cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); base = v[15:0];
      cyc(4'hF, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); check("R7 same-cycle excludes tick", v, exp_cap_word(base));
      cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); check("R7 tick still counted", v, exp_cap_word(base + 16'd1));

      // R8: select change keeps count
      cyc(4'h0, 1'b1, 1'b1, 4'h4, 32'd1);
      read(4'h4, v); base = v[15:0];
      cyc(4'h0, 1'b0, 1'b1, 4'h4, 32'd2);
      cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); check("R8 count kept over select change", v, exp_cap_word(base));

      // R5: capture holds without sof
      for (int k = 0; k < 5; k++) cyc(4'hF, 1'b0, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); check("R5 capture held", v, exp_cap_word(base));

      // R10: writes elsewhere ignored, unmapped read zero (select stays 2)
      cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); base = v[15:0];
      cyc(4'h0, 1'b0, 1'b1, 4'h0, 32'd0);
      cyc(4'h0, 1'b0, 1'b1, 4'h8, 32'd0);
      cyc(4'b0100, 1'b0, 1'b0, 4'h0, 32'h0);
      cyc(4'b1011, 1'b0, 1'b0, 4'h0, 32'h0);
      cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); check("R10 stray write ignored", v, exp_cap_word(base + 16'd1));
      read(4'hC, v); check("R10 unmapped read", v, 32'h0);
      read(4'h0, v); check("R10 unmapped read 0", v, 32'h0);

      // R9: time counter
      read(4'h8, t0);
      idle(10);
      read(4'h8, v); check("R9 time +10", v, t0 + 32'd10);

      // R6: wrap, not cleared by capture
      cyc(4'h0, 1'b1, 1'b1, 4'h4, 32'd0);
      read(4'h4, v); base = v[15:0];
      for (int k = 0; k < 65536; k++) begin
         cyc(4'b0001, (k % 4096) == 7, 1'b0, 4'h0, 32'h0);
      end
      cyc(4'h0, 1'b1, 1'b0, 4'h0, 32'h0);
      read(4'h4, v); check("R6 wrap modulo 2^16", v, exp_cap_word(base));

      // Random traffic against the model (R2 R3 R4 R5 R7 R9 R10)
      for (int k = 0; k < 3000; k++) begin
         logic [3:0] t;
         logic s, we;
         logic [3:0] wa;
         t  = 4'($urandom);
         s  = ($urandom % 8) == 0;
         we = ($urandom % 16) == 0;
         wa = (($urandom % 2) == 0) ? 4'h4 : 4'($urandom);
         cyc(t, s, we, wa, $urandom);
         read(4'h4, v); check("R4 random capture", v, exp_cap_word(m_cap));
         read(4'h8, v); check("R9 random time", v, m_time);
      end

      finish_run();
   end
endmodule